// File: doc/BRIEF.md
# Lateral Guidance Mode Selector

This block selects which of four lateral guidance modes is in charge of the aircraft's roll axis: bank-angle hold, selected-heading hold, approach-beacon tracking, and go-around heading hold. Its inputs are Boolean levels: pilot switches, an approach-capture condition and a coupled-side change indication. It also takes the current mode of the companion vertical mode machine. The block forms events from these inputs itself. Each event is the false-to-true transition of an input or of a condition on the vertical mode.

Each clock cycle the block collects the events that apply to the present lateral mode. If several apply, the one with the highest event number wins, and its destination becomes the next mode. Guard terms use the vertical mode as presented in the same cycle as the event. Approach capture is treated as always armed. A system that composes the lateral and vertical machines feeds each machine's registered mode to the other.

Top module: `lat_mode_fsm`

## Requirements
- R1: While reset is asserted, and after its release until an event occurs, lat_mode reads 0. Lateral codes are 0 for bank hold, 1 for heading hold, 2 for approach track and 3 for go-around. Vertical codes on vert_mode are 0 pitch hold, 1 airspeed hold, 2 glide-slope approach and 3 vertical go-around.
- R2: Only false-to-true transitions cause mode changes. If every input keeps its previous-cycle value, lat_mode does not change in the next cycle.
- R3: No event is recognised in the first clock cycle after reset release, even if inputs are already high then.
- R4: A rising edge of sw_goaround moves bank hold, heading hold or approach track to go-around (3).
- R5: vert_mode becoming 3 (from any other code) moves any lateral mode other than go-around to go-around. No other event overrides this.
- R6: In go-around, vert_mode leaving code 3 moves the machine to bank hold (0). This outranks all other events in that mode.
- R7: A rising edge of sw_heading moves heading hold to bank hold. The same edge moves bank hold or go-around to heading hold.
- R8: In approach track, a rising edge of sw_heading moves to bank hold only if vert_mode is not 2 in that same cycle. When vert_mode is 2, the edge is ignored.
- R9: A rising edge of appr_capture moves bank hold or heading hold to approach track (2).
- R10: A rising edge of side_change moves any mode to bank hold. It has the lowest priority of all events.
- R11: A rising edge of sw_sync never changes the lateral mode.
- R12: When several events apply in one cycle, the highest-numbered one decides. The order from low to high is side change, capture, heading switch (three cases), sync, go-around switch, vertical go-around entered, vertical go-around left.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| side_change | input | 1 | Coupled-side change level |
| appr_capture | input | 1 | Approach capture condition level |
| sw_heading | input | 1 | Heading switch level |
| sw_sync | input | 1 | Sync switch level |
| sw_goaround | input | 1 | Go-around switch level |
| vert_mode | input | 2 | Current vertical mode code |
| lat_mode | output | 2 | Current lateral mode code |

## Verification
The checker evaluates several properties on every cycle. Stable inputs must hold the mode. The go-around switch and the vertical go-around entry must both reach go-around, and leaving vertical go-around must drop the machine to bank hold. The heading switch must be ignored during glide-slope approach, and reset must force bank hold. Full priority resolution among simultaneous events cannot be stated as one property. Neither can the masking of the first post-reset cycle. Both are shown by the bench, which sweeps every start mode, every previous and new vertical code and every combination of switch edges against an independently written transition table.

// File: rtl/latm_pkg.sv
package latm_pkg;
  typedef enum logic [1:0] {
    LM_BANK = 2'd0,
    LM_HEAD = 2'd1,
    LM_APPR = 2'd2,
    LM_GOAR = 2'd3
  } lat_mode_e;

  typedef enum logic [1:0] {
    VM_PITCH = 2'd0,
    VM_SPEED = 2'd1,
    VM_GLIDE = 2'd2,
    VM_GOAR  = 2'd3
  } vert_mode_e;

  localparam int NUM_EV = 9;

  // event numbering, ascending priority
  localparam int EV_SIDE   = 1;
  localparam int EV_CAPT   = 2;
  localparam int EV_HD_OFF = 3;
  localparam int EV_HD_ON  = 4;
  localparam int EV_HD_APP = 5;
  localparam int EV_SYNC   = 6;
  localparam int EV_GA_SW  = 7;
  localparam int EV_VGA_IN = 8;
  localparam int EV_VGA_OUT = 9;
endpackage

// File: rtl/latm_edge.sv
module latm_edge #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev_q, prev_d;
  logic         armed_q, armed_d;

  always_comb begin
    prev_d  = lvl;
    armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      prev_q  <= prev_d;
      armed_q <= armed_d;
    end
  end

  // an edge needs a previous sample taken after reset
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign rise[i] = armed_q & ~prev_q[i] & lvl[i];
  end
endmodule

// File: rtl/latm_arb.sv
module latm_arb
  import latm_pkg::*;
(
  input  lat_mode_e        cur_mode,
  input  vert_mode_e       vert_now,
  input  logic [NUM_EV:1]  ev_raw,
  output lat_mode_e        nxt_mode
);
  logic [NUM_EV:1] hit;

  function automatic logic applies(input int ev, input lat_mode_e m, input vert_mode_e v);
    case (ev)
      EV_SIDE:    applies = 1'b1;
      EV_CAPT:    applies = (m == LM_BANK) || (m == LM_HEAD);
      EV_HD_OFF:  applies = (m == LM_HEAD);
      EV_HD_ON:   applies = (m == LM_BANK) || (m == LM_GOAR);
      EV_HD_APP:  applies = (m == LM_APPR) && (v != VM_GLIDE);
      EV_SYNC:    applies = 1'b0;
      EV_GA_SW:   applies = (m != LM_GOAR);
      EV_VGA_IN:  applies = (m != LM_GOAR);
      EV_VGA_OUT: applies = (m == LM_GOAR);
      default:    applies = 1'b0;
    endcase
  endfunction

  function automatic lat_mode_e dest(input int ev);
    case (ev)
      EV_CAPT:   dest = LM_APPR;
      EV_HD_ON:  dest = LM_HEAD;
      EV_GA_SW,
      EV_VGA_IN: dest = LM_GOAR;
      default:   dest = LM_BANK;
    endcase
  endfunction

  for (genvar e = 1; e <= NUM_EV; e++) begin : g_hit
    assign hit[e] = ev_raw[e] & applies(e, cur_mode, vert_now);
  end

  // ascending scan: the last (highest) hit wins
  always_comb begin
    nxt_mode = cur_mode;
    for (int e = 1; e <= NUM_EV; e++) begin
      if (hit[e]) nxt_mode = dest(e);
    end
  end
endmodule

// File: rtl/lat_mode_fsm.sv
module lat_mode_fsm
  import latm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       side_change,
  input  logic       appr_capture,
  input  logic       sw_heading,
  input  logic       sw_sync,
  input  logic       sw_goaround,
  input  logic [1:0] vert_mode,
  output logic [1:0] lat_mode
);
  localparam int NLVL = 7;

  vert_mode_e      vert_now;
  logic [NLVL-1:0] lvl, rise;
  logic [NUM_EV:1] ev_raw;
  lat_mode_e       mode_q, mode_d;

  assign vert_now = vert_mode_e'(vert_mode);

  // levels: side, capture, heading, sync, go-around, vga, not-vga
  assign lvl = {vert_now != VM_GOAR, vert_now == VM_GOAR, sw_goaround,
                sw_sync, sw_heading, appr_capture, side_change};

  latm_edge #(.W(NLVL)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  (lvl),
    .rise (rise)
  );

  always_comb begin
    ev_raw             = '0;
    ev_raw[EV_SIDE]    = rise[0];
    ev_raw[EV_CAPT]    = rise[1];
    ev_raw[EV_HD_OFF]  = rise[2];
    ev_raw[EV_HD_ON]   = rise[2];
    ev_raw[EV_HD_APP]  = rise[2];
    ev_raw[EV_SYNC]    = rise[3];
    ev_raw[EV_GA_SW]   = rise[4];
    ev_raw[EV_VGA_IN]  = rise[5];
    ev_raw[EV_VGA_OUT] = rise[6];
  end

  latm_arb u_arb (
    .cur_mode(mode_q),
    .vert_now(vert_now),
    .ev_raw  (ev_raw),
    .nxt_mode(mode_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= LM_BANK;
    else        mode_q <= mode_d;
  end

  assign lat_mode = mode_q;
endmodule

// File: rtl/lat_mode_chk.sv
module lat_mode_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       side_change,
  input logic       appr_capture,
  input logic       sw_heading,
  input logic       sw_sync,
  input logic       sw_goaround,
  input logic [1:0] vert_mode,
  input logic [1:0] lat_mode
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  always @(posedge clk) begin
    if (!rst_n) assert_reset_bank_R1: assert (lat_mode == 2'd0);
  end

  assert_levels_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && side_change == $past(side_change) && appr_capture == $past(appr_capture)
     && sw_heading == $past(sw_heading) && sw_sync == $past(sw_sync)
     && sw_goaround == $past(sw_goaround) && vert_mode == $past(vert_mode))
    |=> $stable(lat_mode));

  assert_ga_switch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $rose(sw_goaround) && lat_mode != 2'd3) |=> lat_mode == 2'd3);

  assert_vga_enter_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $rose(vert_mode == 2'd3) && lat_mode != 2'd3) |=> lat_mode == 2'd3);

  assert_vga_leave_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $fell(vert_mode == 2'd3) && lat_mode == 2'd3) |=> lat_mode == 2'd0);

  assert_heading_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && lat_mode == 2'd2 && vert_mode == 2'd2 && !$rose(sw_goaround)
     && !$rose(side_change)) |=> lat_mode == 2'd2);
endmodule

bind lat_mode_fsm lat_mode_chk u_chk (
  .clk(clk), .rst_n(rst_n), .side_change(side_change), .appr_capture(appr_capture),
  .sw_heading(sw_heading), .sw_sync(sw_sync), .sw_goaround(sw_goaround),
  .vert_mode(vert_mode), .lat_mode(lat_mode)
);

// File: tb/sim_lat_mode_fsm.sv
`timescale 1ns/1ps
module sim_lat_mode_fsm;
  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       side_change = 0, appr_capture = 0, sw_heading = 0, sw_sync = 0, sw_goaround = 0;
  logic [1:0] vert_mode = 0;
  logic [1:0] lat_mode;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lat_mode_fsm u0 (
    .clk(clk), .rst_n(rst_n), .side_change(side_change), .appr_capture(appr_capture),
    .sw_heading(sw_heading), .sw_sync(sw_sync), .sw_goaround(sw_goaround),
    .vert_mode(vert_mode), .lat_mode(lat_mode)
  );

  task automatic check(input string tag, input logic [1:0] exp);
    n_chk++;
    if (lat_mode !== exp) begin
      n_fail++;
      $display("FAIL %s: lat_mode=%0d expected=%0d", tag, lat_mode, exp);
    end
  endtask

  task automatic all_low();
    side_change = 0; appr_capture = 0; sw_heading = 0; sw_sync = 0; sw_goaround = 0;
  endtask

  // reset with vertical code held, then settle
  task automatic do_reset(input logic [1:0] v);
    @(negedge clk);
    rst_n = 0; all_low(); vert_mode = v;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  function automatic logic [1:0] ref_next(input logic [1:0] m, input logic sd, cp, hd, sy, ga,
                                          input logic [1:0] pv, nv, output string tag);
    logic e8, e9;
    int   n;
    e8 = (pv != 3) && (nv == 3);
    e9 = (pv == 3) && (nv != 3);
    ref_next = m;
    tag = sy ? "R11" : "R2";
    case (m)
      2'd0: if (e8) begin ref_next = 3; tag = "R5"; end
            else if (ga) begin ref_next = 3; tag = "R4"; end
            else if (hd) begin ref_next = 1; tag = "R7"; end
            else if (cp) begin ref_next = 2; tag = "R9"; end
            else if (sd) begin ref_next = 0; tag = "R10"; end
      2'd1: if (e8) begin ref_next = 3; tag = "R5"; end
            else if (ga) begin ref_next = 3; tag = "R4"; end
            else if (hd) begin ref_next = 0; tag = "R7"; end
            else if (cp) begin ref_next = 2; tag = "R9"; end
            else if (sd) begin ref_next = 0; tag = "R10"; end
      2'd2: if (e8) begin ref_next = 3; tag = "R5"; end
            else if (ga) begin ref_next = 3; tag = "R4"; end
            else if (hd && nv != 2) begin ref_next = 0; tag = "R8"; end
            else if (sd) begin ref_next = 0; tag = "R10"; end
            else if (hd) tag = "R8";
      default: if (e9) begin ref_next = 0; tag = "R6"; end
            else if (hd) begin ref_next = 1; tag = "R7"; end
            else if (sd) begin ref_next = 0; tag = "R10"; end
    endcase
    n = int'(sd) + int'(cp) + int'(hd) + int'(sy) + int'(ga) + int'(e8) + int'(e9);
    if (n > 1) tag = {tag, " R12"};
  endfunction

  initial begin : watchdog
    wait (cyc > 150000);
    n_fail++;
    $display("FAIL watchdog: cycles=%0d expected below 150000", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [1:0] pvs[3];
    logic [1:0] exp;
    string tag;
    pvs[0] = 2'd0; pvs[1] = 2'd2; pvs[2] = 2'd3;
    #1 rst_n = 0;
    @(negedge clk);
    check("R1 during reset", 2'd0);

    // R3: inputs already high at release produce no event
    rst_n = 0; sw_heading = 1; sw_goaround = 1; appr_capture = 1; side_change = 1;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check("R3 no event after release", 2'd0);
    all_low();

    for (int pi = 0; pi < 3; pi++) begin
      for (int sm = 0; sm < 4; sm++) begin
        for (int nv = 0; nv < 4; nv++) begin
          for (int c = 0; c < 32; c++) begin
            do_reset(pvs[pi]);
            if (sm == 0 && nv == 0 && c == 0) check("R1 R3 after release", 2'd0);
            // reach start mode with a single pulse
            if (sm == 1) sw_heading = 1;
            if (sm == 2) appr_capture = 1;
            if (sm == 3) sw_goaround = 1;
            @(negedge clk);
            all_low();
            @(negedge clk);
            if (sm == 1) check("R7 setup", 2'd1);
            if (sm == 2) check("R9 setup", 2'd2);
            if (sm == 3) check("R4 setup", 2'd3);
            if (sm == 0) check("R2 setup", 2'd0);
            // stimulus
            side_change = c[0]; appr_capture = c[1]; sw_heading = c[2];
            sw_sync = c[3]; sw_goaround = c[4]; vert_mode = nv[1:0];
            exp = ref_next(sm[1:0], c[0], c[1], c[2], c[3], c[4], pvs[pi], nv[1:0], tag);
            @(negedge clk);
            check(tag, exp);
            // held levels: no further change
            @(negedge clk);
            check("R2 hold", exp);
          end
        end
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule